// File: doc/BRIEF.md
# Dual-Tree Wavelet Analysis Filter Bank

This block splits one stream of signed fixed-point samples into the coefficients of a five-level dual-tree complex wavelet analysis. Two independent trees work on the same input. The real tree and the imaginary tree each have their own low-pass prototype. At every level, each tree runs a 10-tap low-pass and a 10-tap high-pass filter over the newest ten samples of that level. Both outputs are decimated by two. Each level's low-pass result becomes the input of the next level.

Each tree owns a single multiply-accumulate unit. That unit works through taps, filters and levels one product per cycle. A scheduler services pending levels from the shallowest level to the deepest. Samples enter through a valid/ready handshake, and the block holds off new samples while a sample pair is still being worked through the levels. Results leave as tagged beats. Each beat names the tree, the level (1 to 5) and whether it is a detail or an approximation coefficient.

Top module: `dtw_analysis_bank`

## Requirements
- R1: After reset, in_ready is 1 and out_valid is 0. Every level history holds zeros, so the first results are computed against zero padding.
- R2: Both trees take the same input samples. The real tree (out_tree=0) uses low-pass g = {0,-1000,1000,11000,11000,1000,-1000,0,200,-200}. The imaginary tree (out_tree=1) uses g = {-200,200,0,-1000,1000,11000,11000,1000,-1000,0}. Element i multiplies the i-th newest sample of the level (i=0 is the newest). Coefficients carry 14 fraction bits.
- R3: The high-pass coefficients of a tree are h[i] = (-1)^i * g[9-i]. Every filter result is the sum of exactly 10 products.
- R4: A level produces one low-pass and one high-pass result for every two samples that enter it. The pair is computed when the second sample arrives.
- R5: Low-pass results of levels 1 to 4 feed the next level and are not output. The level-5 low-pass result is output with out_approx=1 and out_level=5. High-pass results of level k are output with out_approx=0 and out_level=k.
- R6: An output value is (sum + 8192) shifted right arithmetically by 14, then saturated to the W-bit signed range. That saturated value is also what enters the next level.
- R7: in_ready stays 1 after the first sample of a pair is accepted. It goes to 0 in the cycle after the second sample is accepted, and stays 0 until all work and output for that pair is done. While in_ready is 1, out_valid is 0.
- R8: Within one pair's work, beats appear from the lowest level to the highest. At level 5, the approximation beats come before the detail beats.
- R9: Each result pair leaves as two beats in consecutive cycles, real first, then imaginary, both with the same level and flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input sample offered |
| in_ready | output | 1 | Block can take a sample |
| in_data | input | W | Signed input sample |
| out_valid | output | 1 | Output beat present |
| out_data | output | W | Signed coefficient |
| out_tree | output | 1 | 0 real tree, 1 imaginary tree |
| out_level | output | $clog2(LEVELS+1) | Level number, 1 to LEVELS |
| out_approx | output | 1 | 1 approximation, 0 detail |

## Verification
Assertions check the following on every cycle:
- input is blocked right after a pair closes;
- output is silent while the block is ready;
- every real beat is followed by its imaginary partner with the same tags;
- level tags stay in range;
- approximation beats appear only at the deepest level;
- the tap counter stays in bounds.

Only the bench's scenarios can show the coefficient values themselves. These include the quadrature-mirror high-pass, the round-and-saturate path, the zero-padded start and the cascade order across levels. A scoreboard model predicts every beat for impulse, constant, full-scale and pseudo-random inputs.

// File: rtl/dtw_pkg.sv
package dtw_pkg;
  localparam int TAPS = 10;
  localparam int CW   = 16;
  localparam int CF   = 14;

  localparam logic signed [CW-1:0] LP_REAL [TAPS] =
    '{16'sd0, -16'sd1000, 16'sd1000, 16'sd11000, 16'sd11000,
      16'sd1000, -16'sd1000, 16'sd0, 16'sd200, -16'sd200};
  localparam logic signed [CW-1:0] LP_IMAG [TAPS] =
    '{-16'sd200, 16'sd200, 16'sd0, -16'sd1000, 16'sd1000,
      16'sd11000, 16'sd11000, 16'sd1000, -16'sd1000, 16'sd0};

  // Low-pass from the table, high-pass as its alternating-sign mirror.
  function automatic logic signed [CW-1:0] coef(input logic tree, input logic hp, input int tap);
    int idx;
    logic signed [CW-1:0] g;
    idx = hp ? (TAPS - 1 - tap) : tap;
    g = tree ? LP_IMAG[idx] : LP_REAL[idx];
    return (hp && (tap % 2 == 1)) ? -g : g;
  endfunction
endpackage

// File: rtl/dtw_sched.sv
module dtw_sched #(
  parameter int LEVELS = 5,
  parameter int TAPS   = 10,
  parameter int LW     = $clog2(LEVELS),
  parameter int TW     = $clog2(TAPS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_fire,
  output logic          run,
  output logic [LW-1:0] lvl,
  output logic [TW-1:0] tap,
  output logic          hp,
  output logic          acc_en,
  output logic          acc_clr,
  output logic          push,
  output logic          emit,
  output logic          pair_close,
  output logic          pend_any
);
  logic [LEVELS-1:0] ph, pend, pend_set, pend_clr, ph_tgl;
  logic [LW-1:0] first;
  logic fin;

  assign pend_any   = |pend;
  assign pair_close = in_fire && ph[0];
  assign acc_en     = run && !fin;
  assign acc_clr    = (tap == '0);
  assign push       = run && fin && !hp && (lvl != LW'(LEVELS-1));
  assign emit       = run && fin && (hp || lvl == LW'(LEVELS-1));

  always_comb begin
    first = '0;
    for (int l = LEVELS-1; l >= 0; l--) if (pend[l]) first = LW'(l);
  end

  always_comb begin
    ph_tgl = '0; pend_set = '0; pend_clr = '0;
    if (in_fire) begin
      ph_tgl[0] = 1'b1;
      pend_set[0] = ph[0];
    end
    for (int l = 1; l < LEVELS; l++)
      if (push && lvl == LW'(l-1)) begin
        ph_tgl[l] = 1'b1;
        pend_set[l] = ph[l];
      end
    if (!run && pend_any) pend_clr[first] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph <= '0; pend <= '0; run <= 1'b0; lvl <= '0;
      tap <= '0; hp <= 1'b0; fin <= 1'b0;
    end else begin
      ph   <= ph ^ ph_tgl;
      pend <= (pend | pend_set) & ~pend_clr;
      if (!run) begin
        if (pend_any) begin
          lvl <= first; run <= 1'b1; hp <= 1'b0; tap <= '0; fin <= 1'b0;
        end
      end else if (fin) begin
        fin <= 1'b0;
        tap <= '0;
        if (!hp) hp <= 1'b1;
        else run <= 1'b0;
      end else if (tap == TW'(TAPS-1)) begin
        fin <= 1'b1;
      end else begin
        tap <= tap + 1'b1;
      end
    end
  end

  a_r3_tap_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (tap < TW'(TAPS)));
endmodule

// File: rtl/dtw_tree.sv
module dtw_tree
  import dtw_pkg::*;
#(
  parameter int W      = 18,
  parameter int LEVELS = 5,
  parameter bit TREE   = 1'b0,
  parameter int LW     = $clog2(LEVELS),
  parameter int TW     = $clog2(TAPS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_fire,
  input  logic signed [W-1:0] in_sample,
  input  logic [LW-1:0]       lvl,
  input  logic [TW-1:0]       tap,
  input  logic                hp,
  input  logic                acc_en,
  input  logic                acc_clr,
  input  logic                push,
  output logic signed [W-1:0] res
);
  localparam int AW = W + CW + 4;
  localparam logic signed [AW-1:0] HALF = AW'(1) <<< (CF-1);
  localparam logic signed [AW-1:0] MAXV = (AW'(1) <<< (W-1)) - AW'(1);
  localparam logic signed [AW-1:0] MINV = -(AW'(1) <<< (W-1));

  function automatic logic signed [W-1:0] round_sat(input logic signed [AW-1:0] a);
    logic signed [AW-1:0] s;
    s = (a + HALF) >>> CF;
    if (s > MAXV) return MAXV[W-1:0];
    if (s < MINV) return MINV[W-1:0];
    return s[W-1:0];
  endfunction

  logic signed [W-1:0] hist [LEVELS][TAPS];
  logic [LEVELS-1:0] shift_en;
  logic signed [AW-1:0] acc, prod;
  logic signed [CW-1:0] cval;

  always_comb begin
    shift_en = '0;
    shift_en[0] = in_fire;
    for (int l = 1; l < LEVELS; l++) shift_en[l] = push && (lvl == LW'(l-1));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int l = 0; l < LEVELS; l++)
        for (int t = 0; t < TAPS; t++) hist[l][t] <= '0;
    end else begin
      for (int l = 0; l < LEVELS; l++)
        if (shift_en[l]) begin
          for (int t = TAPS-1; t > 0; t--) hist[l][t] <= hist[l][t-1];
          hist[l][0] <= (l == 0) ? in_sample : res;
        end
    end
  end

  assign cval = coef(TREE, hp, int'(tap));
  assign prod = AW'(cval) * AW'(hist[lvl][tap]);
  assign res  = round_sat(acc);

  always_ff @(posedge clk) begin
    if (!rst_n) acc <= '0;
    else if (acc_en) acc <= (acc_clr ? '0 : acc) + prod;
  end
endmodule

// File: rtl/dtw_analysis_bank.sv
module dtw_analysis_bank #(
  parameter int W      = 18,
  parameter int LEVELS = 5
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          in_valid,
  output logic                          in_ready,
  input  logic [W-1:0]                  in_data,
  output logic                          out_valid,
  output logic [W-1:0]                  out_data,
  output logic                          out_tree,
  output logic [$clog2(LEVELS+1)-1:0]   out_level,
  output logic                          out_approx
);
  localparam int LW  = $clog2(LEVELS);
  localparam int TW  = $clog2(dtw_pkg::TAPS);
  localparam int LVW = $clog2(LEVELS+1);

  logic in_fire, run, hp, acc_en, acc_clr, push, emit, pair_close, pend_any;
  logic [LW-1:0] lvl;
  logic [TW-1:0] tap;
  logic signed [W-1:0] res [2];
  logic [W-1:0] hold;
  logic second;

  assign in_fire  = in_valid && in_ready;
  assign in_ready = !(run || pend_any || out_valid);

  dtw_sched #(.LEVELS(LEVELS), .TAPS(dtw_pkg::TAPS)) u_sched (
    .clk(clk), .rst_n(rst_n), .in_fire(in_fire), .run(run), .lvl(lvl),
    .tap(tap), .hp(hp), .acc_en(acc_en), .acc_clr(acc_clr), .push(push),
    .emit(emit), .pair_close(pair_close), .pend_any(pend_any));

  for (genvar t = 0; t < 2; t++) begin : g_tree
    dtw_tree #(.W(W), .LEVELS(LEVELS), .TREE(t[0])) u_tree (
      .clk(clk), .rst_n(rst_n), .in_fire(in_fire), .in_sample(in_data),
      .lvl(lvl), .tap(tap), .hp(hp), .acc_en(acc_en), .acc_clr(acc_clr),
      .push(push), .res(res[t]));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0; out_data <= '0; out_tree <= 1'b0;
      out_level <= '0; out_approx <= 1'b0; hold <= '0; second <= 1'b0;
    end else if (emit) begin
      out_valid  <= 1'b1;
      out_tree   <= 1'b0;
      out_data   <= res[0];
      hold       <= res[1];
      out_level  <= LVW'(lvl) + LVW'(1);
      out_approx <= !hp;
      second     <= 1'b1;
    end else if (second) begin
      out_tree <= 1'b1;
      out_data <= hold;
      second   <= 1'b0;
    end else begin
      out_valid <= 1'b0;
    end
  end

  a_r7_pair_blocks_input: assert property (@(posedge clk) disable iff (!rst_n)
    pair_close |=> !in_ready);
  a_r7_quiet_when_ready: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> !out_valid);
  a_r9_imag_follows_real: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_tree) |=> (out_valid && out_tree && $stable(out_level) && $stable(out_approx)));
  a_r5_approx_deepest: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_approx) |-> (out_level == LVW'(LEVELS)));
  a_r5_level_range: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_level >= LVW'(1) && out_level <= LVW'(LEVELS)));
endmodule

// File: tb/tb_dtw_analysis_bank.sv
module tb_dtw_analysis_bank;
  localparam int W = 18;
  localparam int L = 5;
  localparam longint MAXV = (64'sd1 <<< (W-1)) - 1;
  localparam longint MINV = -(64'sd1 <<< (W-1));

  logic clk = 1'b0, rst_n = 1'b0, in_valid = 1'b0;
  logic [W-1:0] in_data = '0;
  logic in_ready, out_valid, out_tree, out_approx;
  logic [W-1:0] out_data;
  logic [2:0] out_level;

  always #2.5 clk = ~clk;

  dtw_analysis_bank #(.W(W), .LEVELS(L)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .out_valid(out_valid), .out_data(out_data),
    .out_tree(out_tree), .out_level(out_level), .out_approx(out_approx));

  typedef struct { bit tree; int level; bit approx; longint val; } beat_t;
  beat_t exp_q[$];
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  longint gre [10] = '{0, -1000, 1000, 11000, 11000, 1000, -1000, 0, 200, -200};
  longint gim [10] = '{-200, 200, 0, -1000, 1000, 11000, 11000, 1000, -1000, 0};
  longint mh [2][L][10];
  bit mph [L];

  function automatic longint cf(int t, bit h, int i);
    longint g;
    g = (t == 1) ? gim[h ? 9-i : i] : gre[h ? 9-i : i];
    return (h && (i % 2 == 1)) ? -g : g;
  endfunction

  function automatic longint fir(int t, bit h, int k);
    longint s = 0, r;
    for (int i = 0; i < 10; i++) s += cf(t, h, i) * mh[t][k][i];
    r = (s + 8192) >>> 14;
    if (r > MAXV) r = MAXV;
    if (r < MINV) r = MINV;
    return r;
  endfunction

  function automatic void shl(int t, int k, longint v);
    for (int i = 9; i > 0; i--) mh[t][k][i] = mh[t][k][i-1];
    mh[t][k][0] = v;
  endfunction

  function automatic void expect_beat(bit t, int lv, bit ap, longint v);
    beat_t b;
    b.tree = t; b.level = lv; b.approx = ap; b.val = v;
    exp_q.push_back(b);
  endfunction

  // Scoreboard model: cascade a pair through the levels, lowest first.
  function automatic void model(longint s);
    longint lo [2], hi [2];
    int k = 0;
    bit go;
    for (int t = 0; t < 2; t++) shl(t, 0, s);
    if (!mph[0]) begin mph[0] = 1; return; end
    mph[0] = 0;
    go = 1;
    while (go) begin
      go = 0;
      for (int t = 0; t < 2; t++) begin lo[t] = fir(t, 0, k); hi[t] = fir(t, 1, k); end
      if (k < L-1) begin
        for (int t = 0; t < 2; t++) shl(t, k+1, lo[t]);
        if (mph[k+1]) begin mph[k+1] = 0; go = 1; end else mph[k+1] = 1;
      end else begin
        expect_beat(0, L, 1, lo[0]); expect_beat(1, L, 1, lo[1]);
      end
      expect_beat(0, k+1, 0, hi[0]); expect_beat(1, k+1, 0, hi[1]);
      k++;
    end
  endfunction

  task automatic check(bit ok, string what, longint act, longint expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, expv);
    end
  endtask

  int n_acc = 0;
  task automatic drive(longint s);
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    in_valid = 1'b1; in_data = s[W-1:0];
    model(s);
    @(posedge clk);
    n_acc++;
    @(negedge clk);
    in_valid = 1'b0;
    // R7: ready drops right after the pair closes, stays up after the first sample
    check(in_ready == ((n_acc % 2) == 1), "R7 in_ready after accept", longint'(in_ready), longint'((n_acc % 2) == 1));
  endtask

  // Monitor
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (exp_q.size() == 0) begin
        check(0, "R8 unexpected beat", longint'(out_level), 0);
      end else begin
        beat_t e;
        e = exp_q.pop_front();
        check(out_tree == e.tree, "R9 R2 tree tag", longint'(out_tree), longint'(e.tree));
        check(int'(out_level) == e.level, "R8 R5 level tag", longint'(out_level), longint'(e.level));
        check(out_approx == e.approx, "R5 approx flag", longint'(out_approx), longint'(e.approx));
        check(longint'($signed(out_data)) == e.val, "R2 R3 R4 R6 value", longint'($signed(out_data)), e.val);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    for (int t = 0; t < 2; t++)
      for (int k = 0; k < L; k++)
        for (int i = 0; i < 10; i++) mh[t][k][i] = 0;
    for (int k = 0; k < L; k++) mph[k] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(in_ready == 1'b1, "R1 reset in_ready", longint'(in_ready), 1);
    check(out_valid == 1'b0, "R1 reset out_valid", longint'(out_valid), 0);
    rst_n = 1'b1;
    // R1: impulse first, results depend on zero padding
    drive(1000);
    for (int i = 0; i < 31; i++) drive(0);
    // constant level
    for (int i = 0; i < 64; i++) drive(5000);
    // full scale, drives saturation (R6)
    for (int i = 0; i < 32; i++) drive(MAXV);
    for (int i = 0; i < 32; i++) drive(MINV);
    // alternating, high-pass heavy (R3)
    for (int i = 0; i < 32; i++) drive((i % 2 == 0) ? 60000 : -60000);
    // pseudo-random
    begin
      int unsigned lf = 32'h1234_5678;
      for (int i = 0; i < 64; i++) begin
        lf = lf ^ (lf << 13); lf = lf ^ (lf >> 17); lf = lf ^ (lf << 5);
        drive(longint'($signed(lf[W-1:0])));
      end
    end
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    repeat (4) @(negedge clk);
    check(exp_q.size() == 0, "R8 all expected beats seen", longint'(exp_q.size()), 0);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule